// File: doc/BRIEF.md
# Reset and Mode-Select Pin Controller

This block owns three shared pads of a small microcontroller: one that can become a dedicated external reset input, one that can become a reset status output, and one that serves as the debug communication and mode-select pin. Three option bits decide what each pad does. While a bit is clear, the pad simply carries the general-purpose port signals. While it is set, the block overrides the pad's direction, output level and pullup.

The block also merges the reset sources into one internal reset. The sources are the asynchronous power-on reset, the external reset pad (after synchronization) and a debug-forced reset request. The internal reset is held for a fixed number of clocks after the last source goes away. The mode-select level is sampled only at the release of a power-on or debug-forced reset. It selects between normal run mode and background-debug mode, and that choice is kept across any other reset.

Top module: `rstmode_pin_ctrl`

## Requirements
- R1: After power-on reset, the read-back `rd_data` is 3'b100. Bit 0 is the reset-input enable, bit 1 the reset-output enable and bit 2 the debug-pin enable.
- R2: Writing 1 to bit 0 sets the reset-input enable. Later writes and non-power-on resets leave it set. Only power-on reset clears it.
- R3: While the reset-input enable is set, the pad's output enable is 0 and its pullup is 1. A low pad level, after a `SYNC_STAGES`-flop synchronizer, asserts `sys_rst`.
- R4: The reset-output enable (bit 1) is set-once in the same way as bit 0 and does not depend on it. While it is set, the pad's output enable is 1, its pullup is 0 and its output equals the inverse of `sys_rst`.
- R5: Every reset of any kind sets the debug-pin enable. Outside reset, software writes it freely through bit 2. While it is set, the debug pad's output enable is 0 and its pullup is 1.
- R6: For each pad whose role bit is clear, the pad's output, output enable and pullup follow `gpio_o`, `gpio_oe` and `gpio_pu` at index 0 (reset input), 1 (reset output) or 2 (debug pin).
- R7: `sys_rst` is high while any source is active. It stays high for exactly `STRETCH_CYCLES` clocks after the last source deasserts. A debug-forced reset request asserts it in the same cycle.
- R8: At the release edge of a reset that contained a power-on or debug-forced reset, `bdm_mode` takes the synchronized debug pad level: low gives 1 (background debug), high gives 0 (normal).
- R9: A reset caused only by the external pad does not resample the mode pin, and `bdm_mode` keeps its value. `bdm_mode` never changes while `sys_rst` is low.
- R10: `rd_data` always shows the three option bits. A write made while `sys_rst` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dbg_force_rst | input | 1 | Debug-forced reset request, sampled each clock |
| wr_en | input | 1 | Option register write strobe |
| wr_data | input | 3 | Option write value {debug, reset-out, reset-in} |
| rd_data | output | 3 | Current option bits, same layout |
| gpio_o | input | 3 | Port output values for the three pads |
| gpio_oe | input | 3 | Port output enables for the three pads |
| gpio_pu | input | 3 | Port pullup enables for the three pads |
| rin_pad_i | input | 1 | Reset-input pad level |
| rin_pad_o | output | 1 | Reset-input pad output value |
| rin_pad_oe | output | 1 | Reset-input pad output enable |
| rin_pad_pu | output | 1 | Reset-input pad pullup enable |
| rout_pad_o | output | 1 | Reset-output pad output value |
| rout_pad_oe | output | 1 | Reset-output pad output enable |
| rout_pad_pu | output | 1 | Reset-output pad pullup enable |
| dbg_pad_i | input | 1 | Debug/mode pad level |
| dbg_pad_o | output | 1 | Debug pad output value |
| dbg_pad_oe | output | 1 | Debug pad output enable |
| dbg_pad_pu | output | 1 | Debug pad pullup enable |
| sys_rst | output | 1 | Internal reset, active high |
| bdm_mode | output | 1 | 1 = background-debug mode, 0 = normal mode |

## Verification
The hardest case to reach is a reset from the external pad that ends while the mode pin is held low. The bench must show that the earlier mode survives, which means the pad low must not leak into `bdm_mode` through a stale pending sample. To get there, the stimulus first leaves power-on with the pin high and arms both set-once bits. It then pulls the mode pin low and drives the reset pad low. After that release it issues a debug-forced reset without changing the pin, so the same level now has to select background mode. A second power-on reset then shows that the set-once bits clear and that the debug-pin enable comes back.

// File: rtl/prc_pkg.sv
package prc_pkg;
   localparam int OPT_W    = 3;
   localparam int OPT_RIN  = 0;
   localparam int OPT_ROUT = 1;
   localparam int OPT_DBG  = 2;

   typedef struct packed {
      logic dbg;
      logic rout;
      logic rin;
   } opt_t;

   typedef enum logic {
      MODE_RUN = 1'b0,
      MODE_BDM = 1'b1
   } mode_e;
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("prc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/prc_stretch.sv
module prc_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic src,
   output logic rst_o,
   output logic rel_o
);
   localparam int CNT_W = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(HOLD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)             cnt_q <= '0;
      else if (src)            cnt_q <= '0;
      else if (cnt_q != TERM)  cnt_q <= cnt_q + 1'b1;
   end

   assign rst_o = src | (cnt_q != TERM);
   assign rel_o = !src && (cnt_q == LAST);

   AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
      src |=> rst_o);                                   // R7
   AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!arst_n)
      (rst_o && !rel_o) |=> rst_o);                     // R7
endmodule

// File: rtl/prc_opts.sv
module prc_opts
   import prc_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst,
   input  logic wr_en,
   input  opt_t wr_data,
   output opt_t opt_o
);
   opt_t opt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         opt_q.rin  <= 1'b0;
         opt_q.rout <= 1'b0;
         opt_q.dbg  <= 1'b1;
      end else if (sys_rst) begin
         opt_q.dbg  <= 1'b1;
      end else if (wr_en) begin
         opt_q.rin  <= opt_q.rin  | wr_data.rin;
         opt_q.rout <= opt_q.rout | wr_data.rout;
         opt_q.dbg  <= wr_data.dbg;
      end
   end

   assign opt_o = opt_q;

   AST_RIN_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      opt_q.rin |=> opt_q.rin);                         // R2
   AST_ROUT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      opt_q.rout |=> opt_q.rout);                       // R4
   AST_DBG_SET_BY_RST: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst |=> opt_q.dbg);                           // R5
   AST_WR_IN_RST_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst && !opt_q.rin) |=> !opt_q.rin);          // R10
endmodule

// File: rtl/prc_mode.sv
module prc_mode
   import prc_pkg::*;
(
   input  logic  clk,
   input  logic  por_n,
   input  logic  force_req,
   input  logic  rel,
   input  logic  sys_rst,
   input  logic  pin_sync,
   output mode_e mode_o
);
   logic  pend_q;
   mode_e mode_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pend_q <= 1'b1;
         mode_q <= MODE_RUN;
      end else if (force_req) begin
         pend_q <= 1'b1;
      end else if (rel && pend_q) begin
         pend_q <= 1'b0;
         mode_q <= pin_sync ? MODE_RUN : MODE_BDM;
      end
   end

   assign mode_o = mode_q;

   AST_MODE_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst |=> $stable(mode_q));                    // R9
   AST_PEND_AFTER_FORCE: assert property (@(posedge clk) disable iff (!por_n)
      force_req |=> pend_q);                            // R8
endmodule

// File: rtl/prc_padmux.sv
module prc_padmux
   import prc_pkg::*;
(
   input  opt_t       opt,
   input  logic       sys_rst,
   input  logic [2:0] gpio_o,
   input  logic [2:0] gpio_oe,
   input  logic [2:0] gpio_pu,
   output logic       rin_o,
   output logic       rin_oe,
   output logic       rin_pu,
   output logic       rout_o,
   output logic       rout_oe,
   output logic       rout_pu,
   output logic       dbg_o,
   output logic       dbg_oe,
   output logic       dbg_pu
);
   always_comb begin
      rin_o   = gpio_o[OPT_RIN];
      rin_oe  = opt.rin ? 1'b0 : gpio_oe[OPT_RIN];
      rin_pu  = opt.rin ? 1'b1 : gpio_pu[OPT_RIN];

      rout_o  = opt.rout ? !sys_rst : gpio_o[OPT_ROUT];
      rout_oe = opt.rout ? 1'b1     : gpio_oe[OPT_ROUT];
      rout_pu = opt.rout ? 1'b0     : gpio_pu[OPT_ROUT];

      dbg_o   = gpio_o[OPT_DBG];
      dbg_oe  = opt.dbg ? 1'b0 : gpio_oe[OPT_DBG];
      dbg_pu  = opt.dbg ? 1'b1 : gpio_pu[OPT_DBG];
   end
endmodule

// File: rtl/rstmode_pin_ctrl.sv
module rstmode_pin_ctrl
   import prc_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int STRETCH_CYCLES = 16
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       dbg_force_rst,
   input  logic       wr_en,
   input  logic [2:0] wr_data,
   output logic [2:0] rd_data,
   input  logic [2:0] gpio_o,
   input  logic [2:0] gpio_oe,
   input  logic [2:0] gpio_pu,
   input  logic       rin_pad_i,
   output logic       rin_pad_o,
   output logic       rin_pad_oe,
   output logic       rin_pad_pu,
   output logic       rout_pad_o,
   output logic       rout_pad_oe,
   output logic       rout_pad_pu,
   input  logic       dbg_pad_i,
   output logic       dbg_pad_o,
   output logic       dbg_pad_oe,
   output logic       dbg_pad_pu,
   output logic       sys_rst,
   output logic       bdm_mode
);
   generate
      if (STRETCH_CYCLES < 16) begin : g_bad_stretch
         $error("STRETCH_CYCLES must be at least 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   opt_t  opt;
   logic  rin_sync, dbg_sync, src, rel;
   mode_e mode;

   prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rin_sync (
      .clk(clk), .arst_n(por_n), .d(opt.rin ? rin_pad_i : 1'b1), .q(rin_sync));

   prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dbg_sync (
      .clk(clk), .arst_n(por_n), .d(dbg_pad_i), .q(dbg_sync));

   assign src = !rin_sync | dbg_force_rst;

   prc_stretch #(.HOLD(STRETCH_CYCLES)) u_stretch (
      .clk(clk), .arst_n(por_n), .src(src), .rst_o(sys_rst), .rel_o(rel));

   prc_opts u_opts (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en),
      .wr_data(opt_t'(wr_data)), .opt_o(opt));

   prc_mode u_mode (
      .clk(clk), .por_n(por_n), .force_req(dbg_force_rst), .rel(rel),
      .sys_rst(sys_rst), .pin_sync(dbg_sync), .mode_o(mode));

   prc_padmux u_pads (
      .opt(opt), .sys_rst(sys_rst),
      .gpio_o(gpio_o), .gpio_oe(gpio_oe), .gpio_pu(gpio_pu),
      .rin_o(rin_pad_o), .rin_oe(rin_pad_oe), .rin_pu(rin_pad_pu),
      .rout_o(rout_pad_o), .rout_oe(rout_pad_oe), .rout_pu(rout_pad_pu),
      .dbg_o(dbg_pad_o), .dbg_oe(dbg_pad_oe), .dbg_pu(dbg_pad_pu));

   assign rd_data  = opt;
   assign bdm_mode = (mode == MODE_BDM);

   AST_RIN_INPUT_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      rd_data[OPT_RIN] |-> (rin_pad_pu && !rin_pad_oe));              // R3
   AST_ROUT_TRACKS_RST: assert property (@(posedge clk) disable iff (!por_n)
      rd_data[OPT_ROUT] |-> (rout_pad_oe && (rout_pad_o == !sys_rst))); // R4
   AST_DBG_PULLUP: assert property (@(posedge clk) disable iff (!por_n)
      rd_data[OPT_DBG] |-> (dbg_pad_pu && !dbg_pad_oe));               // R5
   AST_FORCE_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      dbg_force_rst |-> sys_rst);                                       // R7
endmodule

// File: tb/rstmode_pin_ctrl_test.sv
module rstmode_pin_ctrl_test;
   localparam int S = 16;

   logic clk = 0;
   logic por_n = 0, force_req = 0, wr_en = 0;
   logic [2:0] wr_data = 0, gpio_o = 3'b101, gpio_oe = 3'b111, gpio_pu = 3'b000;
   logic rin_pad_i = 1, dbg_pad_i = 1;
   logic [2:0] rd_data;
   logic rin_pad_o, rin_pad_oe, rin_pad_pu, rout_pad_o, rout_pad_oe, rout_pad_pu;
   logic dbg_pad_o, dbg_pad_oe, dbg_pad_pu, sys_rst, bdm_mode;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rstmode_pin_ctrl #(.SYNC_STAGES(2), .STRETCH_CYCLES(S)) uut (
      .clk(clk), .por_n(por_n), .dbg_force_rst(force_req), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .gpio_o(gpio_o), .gpio_oe(gpio_oe),
      .gpio_pu(gpio_pu), .rin_pad_i(rin_pad_i), .rin_pad_o(rin_pad_o),
      .rin_pad_oe(rin_pad_oe), .rin_pad_pu(rin_pad_pu), .rout_pad_o(rout_pad_o),
      .rout_pad_oe(rout_pad_oe), .rout_pad_pu(rout_pad_pu), .dbg_pad_i(dbg_pad_i),
      .dbg_pad_o(dbg_pad_o), .dbg_pad_oe(dbg_pad_oe), .dbg_pad_pu(dbg_pad_pu),
      .sys_rst(sys_rst), .bdm_mode(bdm_mode));

   // Behavioural reference: pad history queues, stretch counter, role bits.
   bit pin_hist[$];
   bit mode_hist[$];
   int m_cnt;
   bit m_rin, m_rout, m_dbg, m_pend, m_bdm;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pin_hist = '{1, 1};
         mode_hist = '{1, 1};
         m_cnt = 0; m_rin = 0; m_rout = 0; m_dbg = 1; m_pend = 1; m_bdm = 0;
      end else begin
         bit src, rst, rel, old_mode;
         src = !pin_hist[1] || force_req;
         rst = src || (m_cnt != S);
         rel = !src && (m_cnt == S - 1);
         old_mode = mode_hist[1];
         void'(pin_hist.pop_back());
         pin_hist.push_front(m_rin ? rin_pad_i : 1'b1);
         void'(mode_hist.pop_back());
         mode_hist.push_front(dbg_pad_i);
         if (force_req) m_pend = 1;
         else if (rel && m_pend) begin m_bdm = !old_mode; m_pend = 0; end
         if (src) m_cnt = 0;
         else if (m_cnt != S) m_cnt++;
         if (rst) m_dbg = 1;
         else if (wr_en) begin
            m_rin  = m_rin  | wr_data[0];
            m_rout = m_rout | wr_data[1];
            m_dbg  = wr_data[2];
         end
      end
   end

   task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      bit e_rst;
      e_rst = !pin_hist[1] || force_req || (m_cnt != S);
      chk("R10", "rd_data", rd_data, {m_dbg, m_rout, m_rin});
      chk("R7", "sys_rst", {2'b0, sys_rst}, {2'b0, e_rst});
      chk("R8", "bdm_mode", {2'b0, bdm_mode}, {2'b0, m_bdm});
      chk("R3", "rin pad oe/pu/o", {rin_pad_oe, rin_pad_pu, rin_pad_o},
          m_rin ? {2'b01, gpio_o[0]} : {gpio_oe[0], gpio_pu[0], gpio_o[0]});
      chk("R4", "rout pad oe/pu/o", {rout_pad_oe, rout_pad_pu, rout_pad_o},
          m_rout ? {2'b10, !e_rst} : {gpio_oe[1], gpio_pu[1], gpio_o[1]});
      chk("R5", "dbg pad oe/pu/o", {dbg_pad_oe, dbg_pad_pu, dbg_pad_o},
          m_dbg ? {2'b01, gpio_o[2]} : {gpio_oe[2], gpio_pu[2], gpio_o[2]});
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic dchk(string req, string what, logic [2:0] exp, logic [2:0] act);
      @(negedge clk);
      #1;
      chk(req, what, act, exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      dchk("R1", "rd_data in POR", 3'b100, rd_data);
      por_n = 1;
      cyc(S + 4);
      dchk("R1", "rd_data after POR", 3'b100, rd_data);
      dchk("R8", "mode with pin high", 3'b000, {2'b0, bdm_mode});
      // R6: clear debug role, then port patterns pass through
      wr_en = 1; wr_data = 3'b000; cyc(1); wr_en = 0;
      gpio_o = 3'b010; gpio_oe = 3'b101; gpio_pu = 3'b110; cyc(2);
      dchk("R6", "dbg pad gpio oe/pu", {1'b0, gpio_oe[2], gpio_pu[2]}, {1'b0, dbg_pad_oe, dbg_pad_pu});
      gpio_o = 3'b111; gpio_oe = 3'b010; gpio_pu = 3'b001; cyc(2);
      dchk("R6", "rout pad gpio", {gpio_oe[1], gpio_pu[1], gpio_o[1]}, {rout_pad_oe, rout_pad_pu, rout_pad_o});
      // R2 / R4: arm set-once bits, then try to clear them
      wr_en = 1; wr_data = 3'b011; cyc(1);
      wr_data = 3'b000; cyc(1); wr_en = 0; cyc(1);
      dchk("R2", "set-once bits kept", 3'b011, rd_data);
      // R9: external reset with mode pin low must not resample
      dbg_pad_i = 0; cyc(3);
      rin_pad_i = 0; cyc(4);
      dchk("R3", "pad reset asserts", 3'b001, {2'b0, sys_rst});
      dchk("R4", "rout low in reset", 3'b000, {2'b0, rout_pad_o});
      wr_en = 1; wr_data = 3'b000; cyc(1); wr_en = 0;
      dchk("R10", "write in reset ignored", 3'b111, rd_data);
      rin_pad_i = 1; cyc(S + 6);
      dchk("R9", "mode kept after pad reset", 3'b000, {2'b0, bdm_mode});
      dchk("R5", "dbg role back after reset", 3'b111, rd_data);
      // R7 / R8: forced reset with pin low
      force_req = 1; cyc(1); force_req = 0;
      begin
         int n = 0;
         forever begin
            @(negedge clk);
            if (sys_rst) n++; else break;
         end
         chk("R7", "stretch length", n[2:0] == 3'(S) && n == S ? 3'b001 : 3'b000, 3'b001);
      end
      cyc(2);
      dchk("R8", "forced reset pin low", 3'b001, {2'b0, bdm_mode});
      // second POR: set-once bits clear, pin high gives normal mode
      dbg_pad_i = 1; por_n = 0; cyc(2);
      dchk("R2", "POR clears set-once", 3'b100, rd_data);
      por_n = 1; cyc(S + 4);
      dchk("R8", "POR pin high", 3'b000, {2'b0, bdm_mode});
      cyc(3);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule